// File: doc/BRIEF.md
# Two-Level Interrupt Vector Responder

This block sits beside a processor whose address and data share one bus. Two device request lines come in: an urgent line that can never be masked, and an ordinary line gated by an enable input. The block turns them into two registered interrupt request outputs for the processor. It then watches the processor's three bus-control lines to find the interrupt acknowledge cycle. At that point it freezes the winning source. In the vector-strobe cycle that follows, it drives that source's service-routine start address onto the shared bus through a tri-state port.

The block keeps a small in-service register, one bit per level. A level that is in service holds back new requests of its own priority and of lower priority. An urgent request can still nest on top of an ordinary routine in service. The processor's end-of-interrupt output retires the highest level that is in service, so the priority lock lasts for the whole service routine and not only for the acknowledge handshake. The two vector addresses are 16-bit parameters.

Top module: `irqv_resp`

## Requirements
- R1: After reset both request outputs are low, the output enable is low and no level is in service.
- R2: The urgent request output follows `req_hi` one clock later, whatever `lo_en` is, unless the urgent level is in service.
- R3: The ordinary request output is high one clock after `req_lo` and `lo_en` are both high, and only when no level is in service.
- R4: The bus code 3'b111 on {c1,c2,dir} acknowledges while the block is idle. The urgent source wins if its request output is high. Otherwise the ordinary source wins if its output is high. The winner's level is marked in service at that edge.
- R5: After an acknowledge, the first cycle with bus code 3'b010 raises `vec_oe` for exactly that cycle and puts the latched winner's vector on `bus_io` (`VEC_HI` for urgent, `VEC_LO` for ordinary). Request changes between acknowledge and strobe do not alter the vector.
- R6: `vec_oe` is low in every cycle that is not a pending vector strobe, including bus code 3'b000 and a 3'b010 code that no acknowledge preceded.
- R7: While the urgent level is in service, both request outputs stay low. While only the ordinary level is in service, the ordinary output stays low and the urgent output may still rise.
- R8: Each rising edge of `eoi` clears the highest in-service level only. With both levels set, the first clears urgent and the second clears ordinary.
- R9: An acknowledge while neither request output is high marks nothing in service, and the following 3'b010 code does not raise `vec_oe`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_hi | input | 1 | Urgent device request, not maskable |
| req_lo | input | 1 | Ordinary device request |
| lo_en | input | 1 | Enable for the ordinary request |
| bus_ctl | input | 3 | Processor bus code {c1,c2,dir} |
| eoi | input | 1 | Processor end-of-interrupt output; its rising edge retires a level |
| irq_hi_o | output | 1 | Registered urgent request to the processor |
| irq_lo_o | output | 1 | Registered ordinary request to the processor |
| vec_oe | output | 1 | High while the block drives the bus |
| bus_io | inout | 16 | Shared address/data bus, driven only in the vector strobe |

## Verification
The hardest state to reach from the ports is a nested service: the ordinary level acknowledged and in service, then an urgent request acknowledged on top of it, followed by two end-of-interrupt edges that must retire the levels in the right order. A directed sequence builds this case on purpose. A seeded random phase then mixes request levels, enables, bus codes (including stray strobes and acknowledges with nothing pending) and end-of-interrupt pulses, and compares every cycle against a bench model of the in-service register.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
    localparam logic [2:0] BUS_INACTIVE = 3'b000;
    localparam logic [2:0] BUS_VSTROBE  = 3'b010;
    localparam logic [2:0] BUS_ACK      = 3'b111;
    localparam int         LEVELS       = 2;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_VEC  = 1'b1
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic                sel_hi;
        logic [LEVELS-1:0]   isr;
        logic                eoi_prev;
        logic                irq_hi;
        logic                irq_lo;
    } resp_s;
endpackage

// File: rtl/irqv_decode.sv
module irqv_decode
    import irqv_pkg::*;
(
    input  logic [2:0] bus_ctl,
    output logic       is_ack,
    output logic       is_vstrobe
);
    always_comb begin
        is_ack     = (bus_ctl == BUS_ACK);
        is_vstrobe = (bus_ctl == BUS_VSTROBE);
    end
endmodule

// File: rtl/irqv_retire.sv
module irqv_retire #(
    parameter int N = 2
) (
    input  logic [N-1:0] isr_in,
    input  logic         retire,
    output logic [N-1:0] isr_out
);
    logic [N:0] higher_set;

    assign higher_set[N] = 1'b0;

    for (genvar i = N - 1; i >= 0; i--) begin : g_lvl
        assign higher_set[i] = higher_set[i+1] | isr_in[i];
        assign isr_out[i]    = isr_in[i] & ~(retire & ~higher_set[i+1]);
    end
endmodule

// File: rtl/irqv_resp.sv
module irqv_resp
    import irqv_pkg::*;
#(
    parameter logic [15:0] VEC_HI = 16'h1004,
    parameter logic [15:0] VEC_LO = 16'h1008
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_hi,
    input  logic        req_lo,
    input  logic        lo_en,
    input  logic [2:0]  bus_ctl,
    input  logic        eoi,
    output logic        irq_hi_o,
    output logic        irq_lo_o,
    output logic        vec_oe,
    inout  wire  [15:0] bus_io
);
    localparam int HI_BIT = LEVELS - 1;
    localparam int LO_BIT = 0;

    resp_s             st_q, st_d;
    logic              is_ack, is_vstrobe;
    logic              eoi_rise;
    logic [LEVELS-1:0] isr_ret;
    logic [15:0]       vec_word;

    irqv_decode u_dec (
        .bus_ctl    (bus_ctl),
        .is_ack     (is_ack),
        .is_vstrobe (is_vstrobe)
    );

    assign eoi_rise = eoi & ~st_q.eoi_prev;

    irqv_retire #(.N(LEVELS)) u_ret (
        .isr_in  (st_q.isr),
        .retire  (eoi_rise),
        .isr_out (isr_ret)
    );

    always_comb begin
        st_d          = st_q;
        st_d.eoi_prev = eoi;
        st_d.isr      = isr_ret;
        case (st_q.phase)
            PH_IDLE: begin
                if (is_ack) begin
                    if (st_q.irq_hi) begin
                        st_d.phase        = PH_VEC;
                        st_d.sel_hi       = 1'b1;
                        st_d.isr[HI_BIT]  = 1'b1;
                    end else if (st_q.irq_lo) begin
                        st_d.phase        = PH_VEC;
                        st_d.sel_hi       = 1'b0;
                        st_d.isr[LO_BIT]  = 1'b1;
                    end
                end
            end
            PH_VEC: begin
                if (is_vstrobe) begin
                    st_d.phase = PH_IDLE;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
        st_d.irq_hi = req_hi & ~st_d.isr[HI_BIT];
        st_d.irq_lo = req_lo & lo_en & ~(|st_d.isr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, sel_hi: 1'b0, isr: '0,
                      eoi_prev: 1'b0, irq_hi: 1'b0, irq_lo: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_hi_o = st_q.irq_hi;
    assign irq_lo_o = st_q.irq_lo;
    assign vec_oe   = (st_q.phase == PH_VEC) & is_vstrobe;
    assign vec_word = st_q.sel_hi ? VEC_HI : VEC_LO;
    assign bus_io   = vec_oe ? vec_word : 16'bz;
endmodule

// File: rtl/irqv_resp_chk.sv
module irqv_resp_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] bus_ctl,
    input logic       lo_en,
    input logic       eoi,
    input logic       eoi_prev,
    input logic       irq_hi_o,
    input logic       irq_lo_o,
    input logic       vec_oe,
    input logic [1:0] isr,
    input logic       sel_hi,
    input logic       phase
);
    // R6
    oe_only_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe |-> bus_ctl == 3'b010);

    // R5
    oe_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe |=> !vec_oe);

    // R3
    lo_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lo_o |-> $past(lo_en));

    // R7
    hi_service_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        isr[1] |-> (!irq_hi_o && !irq_lo_o));

    // R7
    lo_service_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        isr[0] |-> !irq_lo_o);

    // R4
    urgent_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ctl == 3'b111 && !phase && irq_hi_o) |=> (sel_hi && isr[1]));

    // R8
    eoi_retires_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !eoi_prev && isr[1] && bus_ctl != 3'b111) |=> (!isr[1] && isr[0] == $past(isr[0])));
endmodule

bind irqv_resp irqv_resp_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_ctl  (bus_ctl),
    .lo_en    (lo_en),
    .eoi      (eoi),
    .eoi_prev (st_q.eoi_prev),
    .irq_hi_o (irq_hi_o),
    .irq_lo_o (irq_lo_o),
    .vec_oe   (vec_oe),
    .isr      (st_q.isr),
    .sel_hi   (st_q.sel_hi),
    .phase    (st_q.phase)
);

// File: tb/irqv_resp_tb.sv
module irqv_resp_tb;
    localparam int          CLK_PERIOD = 10;
    localparam logic [15:0] V_HI = 16'h1004;
    localparam logic [15:0] V_LO = 16'h1008;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_hi = 1'b0, req_lo = 1'b0, lo_en = 1'b0, eoi = 1'b0;
    logic [2:0]  bus_ctl = 3'b000;
    logic        irq_hi_o, irq_lo_o, vec_oe;
    wire  [15:0] bus_io;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // bench model
    logic [1:0] m_isr = 2'b00;
    logic       m_busy = 1'b0, m_sel = 1'b0, m_eoi_prev = 1'b0;
    logic       m_hi = 1'b0, m_lo = 1'b0;

    irqv_resp #(.VEC_HI(V_HI), .VEC_LO(V_LO)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_hi(req_hi), .req_lo(req_lo),
        .lo_en(lo_en), .bus_ctl(bus_ctl), .eoi(eoi),
        .irq_hi_o(irq_hi_o), .irq_lo_o(irq_lo_o), .vec_oe(vec_oe),
        .bus_io(bus_io)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] retire(input logic [1:0] isr);
        if (isr[1]) return {1'b0, isr[0]};
        return 2'b00;
    endfunction

    // drive one cycle: inputs set now (after a negedge), strobe checked, edge, outputs checked
    task automatic tick(input logic h, input logic l, input logic en,
                        input logic [2:0] ctl, input logic e);
        logic exp_oe;
        logic [1:0] isr_n;
        req_hi = h; req_lo = l; lo_en = en; bus_ctl = ctl; eoi = e;
        #1;
        exp_oe = m_busy && (ctl == 3'b010);
        check("R6/R5 vec_oe", {15'd0, vec_oe}, {15'd0, exp_oe});
        if (exp_oe) check("R5 vector", bus_io, m_sel ? V_HI : V_LO);
        @(posedge clk);
        isr_n = (e && !m_eoi_prev) ? retire(m_isr) : m_isr;
        m_eoi_prev = e;
        if (!m_busy && ctl == 3'b111) begin
            if (m_hi)      begin m_busy = 1'b1; m_sel = 1'b1; isr_n[1] = 1'b1; end
            else if (m_lo) begin m_busy = 1'b1; m_sel = 1'b0; isr_n[0] = 1'b1; end
        end else if (m_busy && ctl == 3'b010) begin
            m_busy = 1'b0;
        end
        m_isr = isr_n;
        m_hi  = h && !isr_n[1];
        m_lo  = l && en && (isr_n == 2'b00);
        @(negedge clk);
        check("R2/R7 irq_hi_o", {15'd0, irq_hi_o}, {15'd0, m_hi});
        check("R3/R7 irq_lo_o", {15'd0, irq_lo_o}, {15'd0, m_lo});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 irq_hi_o", {15'd0, irq_hi_o}, 16'd0);
        check("R1 irq_lo_o", {15'd0, irq_lo_o}, 16'd0);
        check("R1 vec_oe",   {15'd0, vec_oe},   16'd0);

        // R3: lo request without enable is ignored, then with enable
        tick(0, 1, 0, 3'b000, 0);
        tick(0, 1, 1, 3'b000, 0);
        // R9: stray strobe without ack does not drive
        tick(0, 1, 1, 3'b010, 0);
        // R4/R5: ordinary ack, then request drop before strobe
        tick(0, 1, 1, 3'b111, 0);
        tick(1, 0, 1, 3'b000, 0);
        tick(1, 0, 1, 3'b010, 0);
        // R7: ordinary in service, urgent still raised; nest urgent
        tick(1, 1, 1, 3'b000, 0);
        tick(1, 1, 1, 3'b111, 0);
        tick(0, 1, 1, 3'b010, 0);
        // R8: first eoi retires urgent, second retires ordinary
        tick(0, 1, 1, 3'b000, 1);
        tick(0, 1, 1, 3'b000, 0);
        tick(0, 1, 1, 3'b000, 1);
        tick(0, 1, 1, 3'b000, 0);
        // R4: both pending, urgent wins
        tick(1, 1, 1, 3'b000, 0);
        tick(1, 1, 1, 3'b111, 0);
        tick(1, 1, 1, 3'b010, 0);
        tick(0, 0, 1, 3'b000, 1);
        tick(0, 0, 1, 3'b000, 0);
        // R9: ack with nothing pending, then strobe
        tick(0, 0, 0, 3'b111, 0);
        tick(0, 0, 0, 3'b010, 0);

        // random phase
        for (int i = 0; i < 2000; i++) begin
            logic [2:0] c;
            r = $urandom;
            case (r[3:2])
                2'd0: c = 3'b000;
                2'd1: c = 3'b111;
                2'd2: c = 3'b010;
                default: c = r[10:8];
            endcase
            tick(r[4] & r[5], r[6], r[7] | r[11], c, r[12] & r[13]);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule